// File: doc/BRIEF.md
# Event energy binning accumulator

This block turns digitized pulse-height events into per-energy histograms held in a shared byte-wide memory. Each event carries a 12-bit ADC code and a 3-bit detector number. When the detector's channel is enabled, the block reads one byte from a translation table to get an 8-bit energy bin. It then adds one to the 16-bit counter for that bin. The counter is stored as two bytes. The low byte is always read and rewritten. The high byte is read and written only when the low byte rolls over, and a counter already at its maximum keeps that value.

Two accumulator banks exist. The acquiring side picks a bank with `acq_bank`, and every event is counted in the bank that was selected when it arrived. A readout strobe fetches one 16-bit counter from the opposite bank and clears both of its bytes. All memory traffic uses a request/grant pair, so the memory can be time-sliced among several users. Read data returns one cycle after a granted read. One event can wait in a holding register while the previous one is still being processed. Any event that arrives when that register is already full is dropped and reported.

Top module: `evt_bin_acc`

## Requirements
- R1: Each accepted event issues a table read at byte address {bit15=0, bits14:3 = ADC code, bits2:0 = detector number}. The byte returned is the energy bin.
- R2: Counter bytes sit at address {bit15=1, bits14:10 = 0, bit9 = bank, bits8:1 = bin, bit0 = byte}. Byte 0 is the low byte.
- R3: When the low byte is below 0xFF, the event takes three granted transactions: the table read, a low-byte read and a low-byte write of value+1. The high byte is not touched.
- R4: When the low byte is 0xFF and the high byte is below 0xFF, the event takes five transactions. It reads the table, the low byte and the high byte, then writes 0x00 to the low byte and high+1 to the high byte.
- R5: A counter at 0xFFFF stays at 0xFFFF. The event makes three reads and no write.
- R6: An event whose detector number is 4 or higher, or whose channel bit in `ch_en` is 0, produces no memory request and changes no counter.
- R7: An event that arrives while an earlier one is still in progress is held in a one-entry register and is counted later.
- R8: When an event arrives while the holding register is full and the engine cannot take the held event in that cycle, the new event is not counted. In that case `evt_drop` is high for exactly the following cycle.
- R9: An event is counted in the bank given by `acq_bank` in the cycle the event is presented.
- R10: A one-cycle `rd_req` with `rd_idx` reads the counter at that index in the bank opposite to `acq_bank`. The result appears on `rd_data` with a one-cycle `rd_done`. Both bytes of that counter are then zero.
- R11: While `mem_req` is high without `mem_gnt`, the request, address, direction and write data hold steady. No write ever targets the table region (bit15=0).
- R12: During and right after reset, `mem_req`, `evt_drop` and `rd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_valid | input | 1 | Event strobe, one cycle per event |
| evt_code | input | 12 | ADC code of the event |
| evt_det | input | 3 | Detector number of the event |
| acq_bank | input | 1 | Bank that collects incoming events |
| ch_en | input | 4 | Per-detector enable, bit n for detector n |
| rd_req | input | 1 | Readout strobe |
| rd_idx | input | 8 | Bin index to read out and clear |
| rd_done | output | 1 | One-cycle pulse, readout value valid |
| rd_data | output | 16 | Counter value read out |
| mem_req | output | 1 | Memory transaction request |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_gnt | input | 1 | Slot grant; a transaction completes when request and grant are both high |
| mem_rdata | input | 8 | Read byte, valid the cycle after a granted read |
| evt_drop | output | 1 | Pulse: an event was lost because the holding register was full |

## Verification
Two situations are hard to reach from the ports. The first is a lost event: it needs one event in flight, a second one waiting and a third arriving on the next cycle. The bench gets there by holding the grant low, so the engine stalls on its first table read, and then presents three events on consecutive cycles. The second is the carry and saturation paths. Reaching them through the event port would take tens of thousands of events, so the bench's memory model preloads counter bytes at 0x12FF and 0xFFFF. A single event then exercises the five-transaction carry and the write-free saturated case.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LUT_RD,
      S_LUT_CAP,
      S_LO_RD,
      S_LO_CAP,
      S_HI_RD,
      S_HI_CAP,
      S_LO_WR,
      S_HI_WR,
      S_RO_LO_RD,
      S_RO_LO_CAP,
      S_RO_HI_RD,
      S_RO_HI_CAP,
      S_RO_LO_WR,
      S_RO_HI_WR
   } eng_state_t;
endpackage

// File: rtl/evt_gate.sv
// Channel qualification and one-entry holding register for events.
module evt_gate #(
   parameter int CODE_W = 12,
   parameter int ID_W   = 3,
   parameter int NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [CODE_W-1:0] evt_code,
   input  logic [ID_W-1:0]   evt_det,
   input  logic              evt_bank,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic              take,
   output logic              pend_vld,
   output logic [CODE_W-1:0] pend_code,
   output logic [ID_W-1:0]   pend_det,
   output logic              pend_bank,
   output logic              drop
);
   localparam int NID = 1 << ID_W;

   logic [NID-1:0] id_ok;
   logic           accept;

   for (genvar g = 0; g < NID; g++) begin : g_id
      if (g < NUM_CH) begin : g_ch
         assign id_ok[g] = ch_en[g];
      end else begin : g_off
         assign id_ok[g] = 1'b0;
      end
   end

   assign accept = evt_valid && id_ok[evt_det];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_vld  <= 1'b0;
         pend_code <= '0;
         pend_det  <= '0;
         pend_bank <= 1'b0;
         drop      <= 1'b0;
      end else begin
         drop <= accept && pend_vld && !take;
         if (take) pend_vld <= 1'b0;
         if (accept && (!pend_vld || take)) begin
            pend_vld  <= 1'b1;
            pend_code <= evt_code;
            pend_det  <= evt_det;
            pend_bank <= evt_bank;
         end
      end
   end
endmodule

// File: rtl/acc_addr_map.sv
// Builds the byte address for table and counter accesses.
module acc_addr_map #(
   parameter int CODE_W = 12,
   parameter int ID_W   = 3,
   parameter int BIN_W  = 8,
   parameter int ADDR_W = 16
) (
   input  logic              sel_lut,
   input  logic [CODE_W-1:0] code,
   input  logic [ID_W-1:0]   det,
   input  logic              bank,
   input  logic [BIN_W-1:0]  bin,
   input  logic              hb,
   output logic [ADDR_W-1:0] addr
);
   localparam int BANK_POS = 1 + BIN_W;

   always_comb begin
      addr = '0;
      if (sel_lut) begin
         addr[ID_W-1:0]      = det;
         addr[ID_W+:CODE_W]  = code;
         addr[ADDR_W-1]      = 1'b0;
      end else begin
         addr[0]             = hb;
         addr[1+:BIN_W]      = bin;
         addr[BANK_POS]      = bank;
         addr[ADDR_W-1]      = 1'b1;
      end
   end
endmodule

// File: rtl/acc_engine.sv
// Sequencer for table lookup, byte-wise increment and readout-with-clear.
module acc_engine
   import acc_pkg::*;
#(
   parameter int CODE_W   = 12,
   parameter int ID_W     = 3,
   parameter int BIN_W    = 8,
   parameter bit SATURATE = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pend_vld,
   input  logic [CODE_W-1:0]   pend_code,
   input  logic [ID_W-1:0]     pend_det,
   input  logic                pend_bank,
   input  logic                acq_bank,
   input  logic                rd_req,
   input  logic [BIN_W-1:0]    rd_idx,
   input  logic                mem_gnt,
   input  logic [BYTE_W-1:0]   mem_rdata,
   output logic                take,
   output logic                mem_req,
   output logic                mem_we,
   output logic [BYTE_W-1:0]   mem_wdata,
   output logic                a_lut,
   output logic [CODE_W-1:0]   a_code,
   output logic [ID_W-1:0]     a_det,
   output logic                a_bank,
   output logic [BIN_W-1:0]    a_bin,
   output logic                a_hb,
   output logic                rd_done,
   output logic [2*BYTE_W-1:0] rd_data
);
   localparam logic [BYTE_W-1:0] FULL = '1;

   eng_state_t          state;
   logic [CODE_W-1:0]   cur_code;
   logic [ID_W-1:0]     cur_det;
   logic                cur_bank;
   logic [BIN_W-1:0]    cur_bin;
   logic [BYTE_W-1:0]   lo_q, hi_q;
   logic                ro_pend, ro_bank_q;
   logic [BIN_W-1:0]    ro_idx_q;
   logic                ro_active;
   logic                sat_stop;

   if (SATURATE) begin : g_sat
      assign sat_stop = (mem_rdata == FULL);
   end else begin : g_wrap
      assign sat_stop = 1'b0;
   end

   assign ro_active = (state == S_RO_LO_RD) || (state == S_RO_LO_CAP) ||
                      (state == S_RO_HI_RD) || (state == S_RO_HI_CAP) ||
                      (state == S_RO_LO_WR) || (state == S_RO_HI_WR);
   assign take = (state == S_IDLE) && pend_vld;

   assign a_code = cur_code;
   assign a_det  = cur_det;
   assign a_bank = cur_bank;
   assign a_bin  = cur_bin;

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_wdata = '0;
      a_lut     = 1'b0;
      a_hb      = 1'b0;
      unique case (state)
         S_LUT_RD:   begin mem_req = 1'b1; a_lut = 1'b1; end
         S_LO_RD:    mem_req = 1'b1;
         S_HI_RD:    begin mem_req = 1'b1; a_hb = 1'b1; end
         S_LO_WR:    begin mem_req = 1'b1; mem_we = 1'b1; mem_wdata = lo_q + 1'b1; end
         S_HI_WR:    begin mem_req = 1'b1; mem_we = 1'b1; a_hb = 1'b1; mem_wdata = hi_q + 1'b1; end
         S_RO_LO_RD: mem_req = 1'b1;
         S_RO_HI_RD: begin mem_req = 1'b1; a_hb = 1'b1; end
         S_RO_LO_WR: begin mem_req = 1'b1; mem_we = 1'b1; end
         S_RO_HI_WR: begin mem_req = 1'b1; mem_we = 1'b1; a_hb = 1'b1; end
         default:    ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= S_IDLE;
         cur_code  <= '0;
         cur_det   <= '0;
         cur_bank  <= 1'b0;
         cur_bin   <= '0;
         lo_q      <= '0;
         hi_q      <= '0;
         ro_pend   <= 1'b0;
         ro_bank_q <= 1'b0;
         ro_idx_q  <= '0;
         rd_done   <= 1'b0;
         rd_data   <= '0;
      end else begin
         rd_done <= 1'b0;
         if (rd_req && !ro_pend && !ro_active) begin
            ro_pend   <= 1'b1;
            ro_idx_q  <= rd_idx;
            ro_bank_q <= ~acq_bank;
         end
         unique case (state)
            S_IDLE: begin
               if (pend_vld) begin
                  cur_code <= pend_code;
                  cur_det  <= pend_det;
                  cur_bank <= pend_bank;
                  state    <= S_LUT_RD;
               end else if (ro_pend) begin
                  ro_pend  <= 1'b0;
                  cur_bin  <= ro_idx_q;
                  cur_bank <= ro_bank_q;
                  state    <= S_RO_LO_RD;
               end
            end
            S_LUT_RD:  if (mem_gnt) state <= S_LUT_CAP;
            S_LUT_CAP: begin
               cur_bin <= mem_rdata[BIN_W-1:0];
               state   <= S_LO_RD;
            end
            S_LO_RD:   if (mem_gnt) state <= S_LO_CAP;
            S_LO_CAP: begin
               lo_q  <= mem_rdata;
               state <= (mem_rdata == FULL) ? S_HI_RD : S_LO_WR;
            end
            S_HI_RD:   if (mem_gnt) state <= S_HI_CAP;
            S_HI_CAP: begin
               hi_q  <= mem_rdata;
               state <= sat_stop ? S_IDLE : S_LO_WR;
            end
            S_LO_WR:   if (mem_gnt) state <= (lo_q == FULL) ? S_HI_WR : S_IDLE;
            S_HI_WR:   if (mem_gnt) state <= S_IDLE;
            S_RO_LO_RD:  if (mem_gnt) state <= S_RO_LO_CAP;
            S_RO_LO_CAP: begin
               lo_q  <= mem_rdata;
               state <= S_RO_HI_RD;
            end
            S_RO_HI_RD:  if (mem_gnt) state <= S_RO_HI_CAP;
            S_RO_HI_CAP: begin
               hi_q  <= mem_rdata;
               state <= S_RO_LO_WR;
            end
            S_RO_LO_WR:  if (mem_gnt) state <= S_RO_HI_WR;
            S_RO_HI_WR: begin
               if (mem_gnt) begin
                  rd_done <= 1'b1;
                  rd_data <= {hi_q, lo_q};
                  state   <= S_IDLE;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/evt_bin_acc.sv
// Top: energy binning accumulator with two banks in byte-wide shared memory.
module evt_bin_acc #(
   parameter int CODE_W   = 12,
   parameter int ID_W     = 3,
   parameter int NUM_CH   = 4,
   parameter int BIN_W    = 8,
   parameter int ADDR_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              evt_valid,
   input  logic [CODE_W-1:0] evt_code,
   input  logic [ID_W-1:0]   evt_det,
   input  logic              acq_bank,
   input  logic [NUM_CH-1:0] ch_en,
   input  logic              rd_req,
   input  logic [BIN_W-1:0]  rd_idx,
   output logic              rd_done,
   output logic [15:0]       rd_data,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_gnt,
   input  logic [7:0]        mem_rdata,
   output logic              evt_drop
);
   localparam int LUT_SPAN = CODE_W + ID_W + 1;
   localparam int ACC_SPAN = BIN_W + 3;

   initial begin
      assert (ADDR_W >= LUT_SPAN) else $error("ADDR_W too small for table region");
      assert (ADDR_W >= ACC_SPAN) else $error("ADDR_W too small for counter region");
      assert (NUM_CH <= (1 << ID_W)) else $error("NUM_CH exceeds detector number range");
      assert (BIN_W <= acc_pkg::BYTE_W) else $error("bin must fit in one table byte");
   end

   logic              take, pend_vld, pend_bank;
   logic [CODE_W-1:0] pend_code;
   logic [ID_W-1:0]   pend_det;
   logic              a_lut, a_bank, a_hb;
   logic [CODE_W-1:0] a_code;
   logic [ID_W-1:0]   a_det;
   logic [BIN_W-1:0]  a_bin;

   evt_gate #(.CODE_W(CODE_W), .ID_W(ID_W), .NUM_CH(NUM_CH)) u_gate (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_det(evt_det), .evt_bank(acq_bank), .ch_en(ch_en), .take(take),
      .pend_vld(pend_vld), .pend_code(pend_code), .pend_det(pend_det),
      .pend_bank(pend_bank), .drop(evt_drop)
   );

   acc_engine #(.CODE_W(CODE_W), .ID_W(ID_W), .BIN_W(BIN_W), .SATURATE(SATURATE)) u_eng (
      .clk(clk), .rst_n(rst_n), .pend_vld(pend_vld), .pend_code(pend_code),
      .pend_det(pend_det), .pend_bank(pend_bank), .acq_bank(acq_bank),
      .rd_req(rd_req), .rd_idx(rd_idx), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
      .take(take), .mem_req(mem_req), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .a_lut(a_lut), .a_code(a_code), .a_det(a_det), .a_bank(a_bank),
      .a_bin(a_bin), .a_hb(a_hb), .rd_done(rd_done), .rd_data(rd_data)
   );

   acc_addr_map #(.CODE_W(CODE_W), .ID_W(ID_W), .BIN_W(BIN_W), .ADDR_W(ADDR_W)) u_map (
      .sel_lut(a_lut), .code(a_code), .det(a_det), .bank(a_bank),
      .bin(a_bin), .hb(a_hb), .addr(mem_addr)
   );
endmodule

// File: rtl/acc_chk.sv
module acc_chk #(
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              evt_valid,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_gnt,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              evt_drop,
   input logic              rd_done
);
   // R11
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R11
   no_table_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr[ADDR_W-1]);

   // R8
   drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_drop |-> $past(evt_valid));

   // R8
   drop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      evt_drop |=> !evt_drop);

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done);
endmodule

bind evt_bin_acc acc_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .mem_req(mem_req),
   .mem_we(mem_we), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .evt_drop(evt_drop), .rd_done(rd_done)
);

// File: tb/tb_evt_bin_acc.sv
module tb_evt_bin_acc;
   timeunit 1ns;
   timeprecision 1ps;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        evt_valid;
   logic [11:0] evt_code;
   logic [2:0]  evt_det;
   logic        acq_bank;
   logic [3:0]  ch_en;
   logic        rd_req;
   logic [7:0]  rd_idx;
   logic        rd_done;
   logic [15:0] rd_data;
   logic        mem_req, mem_we, mem_gnt;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata;
   logic        evt_drop;

   always #2.5 clk = ~clk;

   evt_bin_acc dut (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
      .evt_det(evt_det), .acq_bank(acq_bank), .ch_en(ch_en), .rd_req(rd_req),
      .rd_idx(rd_idx), .rd_done(rd_done), .rd_data(rd_data), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .evt_drop(evt_drop)
   );

   // ---------------- memory model and grant slots ----------------
   logic [7:0]  accm [0:1023];
   int          txn_cnt = 0;
   int          wr_cnt = 0;
   logic [15:0] last_lut = '0;
   int          gcnt = 0;
   int          gmode = 0;   // 0 every cycle, 1 every third cycle, 2 never

   function automatic logic [7:0] lut_bin(input logic [11:0] c, input logic [2:0] d);
      return c[11:4] ^ {d, 5'b00000};
   endfunction

   assign mem_gnt = (gmode == 0) || (gmode == 1 && gcnt == 0);

   always @(posedge clk) begin
      gcnt <= (gcnt == 2) ? 0 : gcnt + 1;
      if (mem_req && mem_gnt) begin
         txn_cnt <= txn_cnt + 1;
         if (mem_we) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr[15]) accm[mem_addr[9:0]] <= mem_wdata;
         end else begin
            if (!mem_addr[15]) last_lut <= mem_addr;
            mem_rdata <= mem_addr[15] ? accm[mem_addr[9:0]]
                                      : lut_bin(mem_addr[14:3], mem_addr[2:0]);
         end
      end
   end

   // ---------------- checking helpers ----------------
   int n_chk = 0;
   int n_err = 0;
   int expc [0:511];
   bit finished = 1'b0;

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_bin(input string req, input logic b, input logic [7:0] bin);
      int v;
      v = {accm[{b, bin, 1'b1}], accm[{b, bin, 1'b0}]};
      check(req, v, expc[{b, bin}]);
   endtask

   task automatic preload(input logic b, input logic [7:0] bin, input logic [15:0] val);
      @(negedge clk);
      accm[{b, bin, 1'b0}] <= val[7:0];
      accm[{b, bin, 1'b1}] <= val[15:8];
      expc[{b, bin}] = val;
   endtask

   task automatic send_evt(input logic [11:0] c, input logic [2:0] d, input logic b);
      @(negedge clk);
      evt_valid = 1'b1; evt_code = c; evt_det = d; acq_bank = b;
      @(negedge clk);
      evt_valid = 1'b0;
   endtask

   task automatic do_read(input logic b, input logic [7:0] idx, output int val);
      @(negedge clk);
      acq_bank = ~b; rd_req = 1'b1; rd_idx = idx;
      @(negedge clk);
      rd_req = 1'b0;
      val = -1;
      for (int k = 0; k < 200; k++) begin
         if (rd_done) begin
            val = rd_data;
            break;
         end
         @(negedge clk);
      end
      expc[{b, idx}] = 0;
   endtask

   // stimulus table: {counted, bank, det, code}
   localparam logic [16:0] VEC [0:7] = '{
      {1'b1, 1'b0, 3'd0, 12'h123},
      {1'b1, 1'b0, 3'd1, 12'h123},
      {1'b1, 1'b1, 3'd0, 12'h123},
      {1'b0, 1'b0, 3'd2, 12'h456},
      {1'b1, 1'b0, 3'd3, 12'hFFF},
      {1'b0, 1'b0, 3'd5, 12'h001},
      {1'b1, 1'b0, 3'd0, 12'h123},
      {1'b1, 1'b1, 3'd3, 12'h000}
   };

   initial begin
      #(5.0 * 150000);
      if (!finished) begin
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      int t0, w0, val;
      logic [7:0] bin;
      rst_n = 1'b0; evt_valid = 1'b0; evt_code = '0; evt_det = '0;
      acq_bank = 1'b0; ch_en = 4'b1011; rd_req = 1'b0; rd_idx = '0;
      for (int i = 0; i < 1024; i++) accm[i] <= 8'h00;
      for (int i = 0; i < 512; i++) expc[i] = 0;
      repeat (3) @(negedge clk);
      // R12 quiet during reset
      check("R12 req in reset", int'(mem_req), 0);
      check("R12 drop in reset", int'(evt_drop), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 req after reset", int'(mem_req), 0);
      check("R12 done after reset", int'(rd_done), 0);

      // table-driven pass: R1 R3 R6 R9
      for (int i = 0; i < 8; i++) begin
         logic [16:0] v;
         v = VEC[i];
         gmode = i % 2;
         t0 = txn_cnt;
         send_evt(v[11:0], v[14:12], v[15]);
         repeat (40) @(negedge clk);
         bin = lut_bin(v[11:0], v[14:12]);
         if (v[16]) begin
            if (expc[{v[15], bin}] < 16'hFFFF) expc[{v[15], bin}]++;
            check("R1 table address", int'(last_lut), int'({1'b0, v[11:0], v[14:12]}));
            check("R3 transactions", txn_cnt - t0, 3);
         end else begin
            check("R6 ignored event transactions", txn_cnt - t0, 0);
         end
         chk_bin("R9 R2 count in bank", v[15], bin);
      end

      // R4 carry into high byte
      gmode = 0;
      bin = lut_bin(12'h7A0, 3'd1);
      preload(1'b1, bin, 16'h12FF);
      t0 = txn_cnt; w0 = wr_cnt;
      send_evt(12'h7A0, 3'd1, 1'b1);
      repeat (40) @(negedge clk);
      expc[{1'b1, bin}] = 16'h1300;
      chk_bin("R4 carry value", 1'b1, bin);
      check("R4 transactions", txn_cnt - t0, 5);
      check("R4 writes", wr_cnt - w0, 2);

      // R5 saturation
      bin = lut_bin(12'hC00, 3'd3);
      preload(1'b0, bin, 16'hFFFF);
      t0 = txn_cnt; w0 = wr_cnt;
      send_evt(12'hC00, 3'd3, 1'b0);
      repeat (40) @(negedge clk);
      chk_bin("R5 saturated value", 1'b0, bin);
      check("R5 transactions", txn_cnt - t0, 3);
      check("R5 writes", wr_cnt - w0, 0);

      // R7 R8 hold register and drop
      ch_en = 4'b1111;
      gmode = 2;
      @(negedge clk);
      evt_valid = 1'b1; evt_code = 12'h200; evt_det = 3'd0; acq_bank = 1'b0;
      @(negedge clk);
      evt_code = 12'h300; evt_det = 3'd1;
      @(negedge clk);
      check("R8 no drop while entry free", int'(evt_drop), 0);
      evt_code = 12'h500; evt_det = 3'd0;
      @(negedge clk);
      evt_valid = 1'b0;
      check("R8 drop pulse", int'(evt_drop), 1);
      @(negedge clk);
      check("R8 drop single cycle", int'(evt_drop), 0);
      gmode = 0;
      repeat (60) @(negedge clk);
      expc[{1'b0, lut_bin(12'h200, 3'd0)}]++;
      expc[{1'b0, lut_bin(12'h300, 3'd1)}]++;
      chk_bin("R7 first event counted", 1'b0, lut_bin(12'h200, 3'd0));
      chk_bin("R7 held event counted", 1'b0, lut_bin(12'h300, 3'd1));
      chk_bin("R8 dropped event not counted", 1'b0, lut_bin(12'h500, 3'd0));

      // R10 readout and clear
      gmode = 1;
      do_read(1'b0, 8'h12, val);
      check("R10 readout value bank0", val, 2);
      chk_bin("R10 cleared bank0", 1'b0, 8'h12);
      chk_bin("R9 other bank untouched", 1'b1, 8'h12);
      do_read(1'b1, lut_bin(12'h7A0, 3'd1), val);
      check("R10 readout carried value", val, 16'h1300);
      chk_bin("R10 cleared bank1", 1'b1, lut_bin(12'h7A0, 3'd1));

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule